// File: doc/BRIEF.md
# Internal Error Status and Forwarding-Enable Logger

This block gathers single-cycle error indications from the internal checkers of a link controller and records them in two classes: severe (uncorrectable) and recoverable (correctable). Each class owns a sticky status register, in which an event sets its bit and software clears it by writing 1, and a forwarding-enable register that decides whether a newly recorded event is passed on as an internal error of that class. One source in each class stands for a configuration-load failure; it is recorded only while the configuration-load mode flag is high.

Both classes keep their contents across a warm reset; only a power-on reset returns them to their defaults. The forwarding outputs are single-cycle pulses, raised once when an enabled status bit goes from 0 to 1, and they feed the message generator that lies outside this block. Software reaches all four registers through one write port and one combinational read port.

Top module: `int_err_logger`

## Requirements
- R1: After a power-on reset both status registers read 0, the severe enable register reads all ones except its configuration bit (bit 6) which reads 0, and the recoverable enable register reads 0. Register select codes: 0 severe status, 1 severe enable, 2 recoverable status, 3 recoverable enable.
- R2: A source pulse sampled at a clock edge sets its status bit, visible from that edge onward, and the bit stays set after the source drops.
- R3: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When a source fires in the same cycle as a write that clears its bit, the bit ends up set.
- R5: The configuration source (severe bit 6, recoverable bit 1) is recorded only while cfg_mode_i is high; with the flag low it has no effect.
- R6: A forwarding output pulses high for exactly the one cycle in which an enabled status bit of its class first reads 1.
- R7: No forwarding pulse follows an event whose enable bit is 0, nor an event on a bit that is already set.
- R8: Enable registers are read/write; a write replaces all implemented bits, and without a write they hold their value.
- R9: A warm reset (hot_rst_n low) leaves status and enable contents unchanged and keeps both forwarding outputs low; events during it are still recorded.
- R10: Register bits above a class's source count read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hot_rst_n | input | 1 | Warm reset, active low, synchronous, clears forwarding only |
| unc_err_i | input | UNC_N (12) | Severe-class event pulses, one per source |
| cor_err_i | input | COR_N (4) | Recoverable-class event pulses, one per source |
| cfg_mode_i | input | 1 | Configuration-load mode flag gating the configuration sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selected for writing |
| wr_data_i | input | REG_W (16) | Write data |
| rd_sel_i | input | 2 | Register selected for reading |
| rd_data_o | output | REG_W (16) | Read data, zero-extended |
| fwd_unc_o | output | 1 | Severe-class forwarding pulse |
| fwd_cor_o | output | 1 | Recoverable-class forwarding pulse |

## Verification
The properties take for granted that the event inputs and the write strobe are held low while por_n is asserted, so that the first sampled history after reset is clean, and that the configuration bit index lies inside each class. The stimulus changes inputs only on the falling edge, returns every event and write to 0 after one cycle, and keeps all sources quiet across the power-on reset. Collisions between a clearing write and an event are applied both to a bit that was set and to one that was clear, which covers the two outcomes of the set-over-clear rule.

// File: rtl/int_err_pkg.sv
package int_err_pkg;
   typedef enum logic [1:0] {
      SEL_UNC_STAT = 2'd0,
      SEL_UNC_EN   = 2'd1,
      SEL_COR_STAT = 2'd2,
      SEL_COR_EN   = 2'd3
   } reg_sel_e;

   // Enable reset image: all ones with the configuration bit cleared, or all zeros.
   function automatic logic [31:0] en_reset_image(input int n, input int cfg_idx, input bit all_on);
      logic [31:0] img;
      img = '0;
      for (int i = 0; i < n; i++) begin
         img[i] = all_on && (i != cfg_idx);
      end
      return img;
   endfunction
endpackage

// File: rtl/err_class_log.sv
module err_class_log #(
   parameter int          N       = 12,
   parameter int          CFG_IDX = 6,
   parameter logic [31:0] EN_RST  = 32'h0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         hot_rst_n,
   input  logic [N-1:0] src_i,
   input  logic         cfg_mode_i,
   input  logic         st_wr_i,
   input  logic         en_wr_i,
   input  logic [N-1:0] wr_data_i,
   output logic [N-1:0] stat_o,
   output logic [N-1:0] en_o,
   output logic         fwd_o
);
   logic [N-1:0] src_g;
   logic [N-1:0] stat_q;
   logic [N-1:0] en_q;
   logic [N-1:0] clr;
   logic [N-1:0] newly;
   logic         fwd_q;

   // Gate the configuration source with the mode flag, pass the rest.
   generate
      for (genvar i = 0; i < N; i++) begin : g_gate
         if (i == CFG_IDX) begin : g_cfg
            assign src_g[i] = src_i[i] & cfg_mode_i;
         end else begin : g_plain
            assign src_g[i] = src_i[i];
         end
      end
   endgenerate

   assign clr   = st_wr_i ? wr_data_i : '0;
   assign newly = src_g & ~stat_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr) | src_g;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q <= EN_RST[N-1:0];
      end else if (en_wr_i) begin
         en_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         fwd_q <= 1'b0;
      end else if (!hot_rst_n) begin
         fwd_q <= 1'b0;
      end else begin
         fwd_q <= |(newly & en_q);
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign fwd_o  = fwd_q;
endmodule

// File: rtl/err_rd_mux.sv
module err_rd_mux
   import int_err_pkg::*;
#(
   parameter int UNC_N = 12,
   parameter int COR_N = 4,
   parameter int REG_W = 16
) (
   input  logic [1:0]       rd_sel_i,
   input  logic [UNC_N-1:0] unc_stat_i,
   input  logic [UNC_N-1:0] unc_en_i,
   input  logic [COR_N-1:0] cor_stat_i,
   input  logic [COR_N-1:0] cor_en_i,
   output logic [REG_W-1:0] rd_data_o
);
   always_comb begin
      unique case (reg_sel_e'(rd_sel_i))
         SEL_UNC_STAT: rd_data_o = REG_W'(unc_stat_i);
         SEL_UNC_EN:   rd_data_o = REG_W'(unc_en_i);
         SEL_COR_STAT: rd_data_o = REG_W'(cor_stat_i);
         SEL_COR_EN:   rd_data_o = REG_W'(cor_en_i);
         default:      rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/int_err_logger.sv
module int_err_logger
   import int_err_pkg::*;
#(
   parameter int UNC_N       = 12,
   parameter int COR_N       = 4,
   parameter int REG_W       = 16,
   parameter int UNC_CFG_IDX = 6,
   parameter int COR_CFG_IDX = 1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             hot_rst_n,
   input  logic [UNC_N-1:0] unc_err_i,
   input  logic [COR_N-1:0] cor_err_i,
   input  logic             cfg_mode_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic [1:0]       rd_sel_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic             fwd_unc_o,
   output logic             fwd_cor_o
);
   localparam logic [31:0] UNC_EN_RST = en_reset_image(UNC_N, UNC_CFG_IDX, 1'b1);
   localparam logic [31:0] COR_EN_RST = en_reset_image(COR_N, COR_CFG_IDX, 1'b0);

   generate
      if (UNC_N > REG_W || COR_N > REG_W || REG_W > 32) begin : g_bad_width
         $error("int_err_logger: source count exceeds register width");
      end
      if (UNC_CFG_IDX >= UNC_N || COR_CFG_IDX >= COR_N) begin : g_bad_cfg
         $error("int_err_logger: configuration bit outside its class");
      end
   endgenerate

   logic [UNC_N-1:0] unc_stat, unc_en;
   logic [COR_N-1:0] cor_stat, cor_en;
   logic             unused_wr;

   assign unused_wr = &{1'b0, wr_data_i};

   err_class_log #(
      .N(UNC_N), .CFG_IDX(UNC_CFG_IDX), .EN_RST(UNC_EN_RST)
   ) u_unc (
      .clk        (clk),
      .por_n      (por_n),
      .hot_rst_n  (hot_rst_n),
      .src_i      (unc_err_i),
      .cfg_mode_i (cfg_mode_i),
      .st_wr_i    (wr_en_i && wr_sel_i == SEL_UNC_STAT),
      .en_wr_i    (wr_en_i && wr_sel_i == SEL_UNC_EN),
      .wr_data_i  (wr_data_i[UNC_N-1:0]),
      .stat_o     (unc_stat),
      .en_o       (unc_en),
      .fwd_o      (fwd_unc_o)
   );

   err_class_log #(
      .N(COR_N), .CFG_IDX(COR_CFG_IDX), .EN_RST(COR_EN_RST)
   ) u_cor (
      .clk        (clk),
      .por_n      (por_n),
      .hot_rst_n  (hot_rst_n),
      .src_i      (cor_err_i),
      .cfg_mode_i (cfg_mode_i),
      .st_wr_i    (wr_en_i && wr_sel_i == SEL_COR_STAT),
      .en_wr_i    (wr_en_i && wr_sel_i == SEL_COR_EN),
      .wr_data_i  (wr_data_i[COR_N-1:0]),
      .stat_o     (cor_stat),
      .en_o       (cor_en),
      .fwd_o      (fwd_cor_o)
   );

   err_rd_mux #(
      .UNC_N(UNC_N), .COR_N(COR_N), .REG_W(REG_W)
   ) u_rd (
      .rd_sel_i   (rd_sel_i),
      .unc_stat_i (unc_stat),
      .unc_en_i   (unc_en),
      .cor_stat_i (cor_stat),
      .cor_en_i   (cor_en),
      .rd_data_o  (rd_data_o)
   );
endmodule

// File: rtl/int_err_logger_chk.sv
module int_err_logger_chk #(
   parameter int UNC_N       = 12,
   parameter int COR_N       = 4,
   parameter int UNC_CFG_IDX = 6,
   parameter int COR_CFG_IDX = 1
) (
   input logic             clk,
   input logic             por_n,
   input logic             hot_rst_n,
   input logic [UNC_N-1:0] unc_err_i,
   input logic             cfg_mode_i,
   input logic             wr_en_i,
   input logic [1:0]       wr_sel_i,
   input logic [UNC_N-1:0] unc_stat,
   input logic [UNC_N-1:0] unc_en,
   input logic [COR_N-1:0] cor_stat,
   input logic [COR_N-1:0] cor_en,
   input logic             fwd_unc_o,
   input logic             fwd_cor_o
);
   localparam logic [UNC_N-1:0] UNC_PLAIN = ~(UNC_N'(1) << UNC_CFG_IDX);

   // R2: every ungated source seen last cycle is recorded now
   p_src_logged_r2: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> ((($past(unc_err_i) & UNC_PLAIN) & ~unc_stat) == '0));

   // R3: a status bit only falls after a write to the severe status register
   p_clear_needs_write_r3: assert property (@(posedge clk) disable iff (!por_n)
      (($past(unc_stat) & ~unc_stat) != '0) |-> ($past(wr_en_i) && $past(wr_sel_i) == 2'd0));

   // R5: configuration bit cannot rise while the mode flag was low
   p_cfg_gated_r5: assert property (@(posedge clk) disable iff (!por_n)
      (!$past(cfg_mode_i) && !$past(unc_stat[UNC_CFG_IDX])) |-> !unc_stat[UNC_CFG_IDX]);

   p_cfg_gated_cor_r5: assert property (@(posedge clk) disable iff (!por_n)
      (!$past(cfg_mode_i) && !$past(cor_stat[COR_CFG_IDX])) |-> !cor_stat[COR_CFG_IDX]);

   // R6: a severe forwarding pulse coincides with a newly set enabled bit
   p_fwd_new_bit_r6: assert property (@(posedge clk) disable iff (!por_n)
      fwd_unc_o |-> ((unc_stat & ~$past(unc_stat) & $past(unc_en)) != '0));

   p_fwd_new_bit_cor_r6: assert property (@(posedge clk) disable iff (!por_n)
      fwd_cor_o |-> ((cor_stat & ~$past(cor_stat) & $past(cor_en)) != '0));

   // R8: enables hold without a write
   p_en_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      !$past(wr_en_i) |-> (unc_en == $past(unc_en) && cor_en == $past(cor_en)));

   // R9: warm reset keeps forwarding quiet
   p_hot_quiet_r9: assert property (@(posedge clk) disable iff (!por_n)
      !$past(hot_rst_n) |-> (!fwd_unc_o && !fwd_cor_o));
endmodule

bind int_err_logger int_err_logger_chk #(
   .UNC_N(UNC_N), .COR_N(COR_N), .UNC_CFG_IDX(UNC_CFG_IDX), .COR_CFG_IDX(COR_CFG_IDX)
) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .hot_rst_n  (hot_rst_n),
   .unc_err_i  (unc_err_i),
   .cfg_mode_i (cfg_mode_i),
   .wr_en_i    (wr_en_i),
   .wr_sel_i   (wr_sel_i),
   .unc_stat   (unc_stat),
   .unc_en     (unc_en),
   .cor_stat   (cor_stat),
   .cor_en     (cor_en),
   .fwd_unc_o  (fwd_unc_o),
   .fwd_cor_o  (fwd_cor_o)
);

// File: tb/int_err_logger_bench.sv
`timescale 1ns/100ps
module int_err_logger_bench;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        hot_rst_n = 1'b1;
   logic [11:0] unc_err = '0;
   logic [3:0]  cor_err = '0;
   logic        cfg_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [15:0] rd_data;
   logic        fwd_unc, fwd_cor;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   int_err_logger u_int_err_logger (
      .clk(clk), .por_n(por_n), .hot_rst_n(hot_rst_n),
      .unc_err_i(unc_err), .cor_err_i(cor_err), .cfg_mode_i(cfg_mode),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .rd_sel_i(rd_sel), .rd_data_o(rd_data),
      .fwd_unc_o(fwd_unc), .fwd_cor_o(fwd_cor)
   );

   typedef struct packed {
      logic [11:0] unc;
      logic [3:0]  cor;
      logic        mode;
      logic        we;
      logic [1:0]  sel;
      logic [15:0] wd;
      logic [11:0] e_unc;
      logic [3:0]  e_cor;
      logic        e_fu;
      logic        e_fc;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{12'h000, 4'h0, 1'b0, 1'b0, 2'd0, 16'h0000, 12'h000, 4'h0, 1'b0, 1'b0}, // idle
      '{12'h001, 4'h0, 1'b0, 1'b0, 2'd0, 16'h0000, 12'h001, 4'h0, 1'b1, 1'b0}, // R2 R6
      '{12'h001, 4'h0, 1'b0, 1'b0, 2'd0, 16'h0000, 12'h001, 4'h0, 1'b0, 1'b0}, // R7 repeat
      '{12'h040, 4'h2, 1'b0, 1'b0, 2'd0, 16'h0000, 12'h001, 4'h0, 1'b0, 1'b0}, // R5 mode low
      '{12'h040, 4'h2, 1'b1, 1'b0, 2'd0, 16'h0000, 12'h041, 4'h2, 1'b0, 1'b0}, // R5 mode high, R7 disabled
      '{12'h000, 4'h0, 1'b0, 1'b1, 2'd0, 16'h0001, 12'h040, 4'h2, 1'b0, 1'b0}, // R3 clear
      '{12'h040, 4'h0, 1'b1, 1'b1, 2'd0, 16'h0040, 12'h040, 4'h2, 1'b0, 1'b0}, // R4 set wins
      '{12'h000, 4'h0, 1'b0, 1'b1, 2'd1, 16'h0FFF, 12'h040, 4'h2, 1'b0, 1'b0}, // R8 enable write
      '{12'h002, 4'h0, 1'b0, 1'b1, 2'd0, 16'h0002, 12'h042, 4'h2, 1'b1, 1'b0}, // R4 R6 clear of clear bit
      '{12'h000, 4'h0, 1'b0, 1'b1, 2'd3, 16'h000F, 12'h042, 4'h2, 1'b0, 1'b0}, // R8 recoverable enable
      '{12'h000, 4'h1, 1'b0, 1'b0, 2'd0, 16'h0000, 12'h042, 4'h3, 1'b0, 1'b1}, // R6 recoverable
      '{12'h000, 4'h0, 1'b0, 1'b1, 2'd2, 16'h000F, 12'h042, 4'h0, 1'b0, 1'b0}, // R3 recoverable clear
      '{12'h800, 4'h0, 1'b0, 1'b0, 2'd0, 16'h0000, 12'h842, 4'h0, 1'b1, 1'b0}, // R2 R6 top bit
      '{12'h000, 4'h0, 1'b0, 1'b1, 2'd0, 16'hFFFF, 12'h000, 4'h0, 1'b0, 1'b0}  // R3 R10 clear all
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic read_reg(input logic [1:0] sel, output logic [15:0] val);
      rd_sel = sel;
      #0.4;
      val = rd_data;
   endtask

   // Drive one cycle of stimulus at a falling edge, return at the next falling edge with inputs idle.
   task automatic cycle(input logic [11:0] u, input logic [3:0] c, input logic m,
                        input logic we, input logic [1:0] sel, input logic [15:0] wd);
      unc_err = u; cor_err = c; cfg_mode = m;
      wr_en = we; wr_sel = sel; wr_data = wd;
      @(negedge clk);
      unc_err = '0; cor_err = '0; cfg_mode = 1'b0;
      wr_en = 1'b0; wr_sel = '0; wr_data = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      // R1 reset image
      read_reg(2'd0, v); check("R1 severe status", v, 16'h0000);
      read_reg(2'd1, v); check("R1 severe enable", v, 16'h0FBF);
      read_reg(2'd2, v); check("R1 recoverable status", v, 16'h0000);
      read_reg(2'd3, v); check("R1 recoverable enable", v, 16'h0000);
      check("R1 forwarding idle", {14'h0, fwd_unc, fwd_cor}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         cycle(VECS[i].unc, VECS[i].cor, VECS[i].mode, VECS[i].we, VECS[i].sel, VECS[i].wd);
         check($sformatf("vec%0d fwd R6 R7", i), {14'h0, fwd_unc, fwd_cor},
               {14'h0, VECS[i].e_fu, VECS[i].e_fc});
         read_reg(2'd0, v); check($sformatf("vec%0d severe status R2-path", i), v, {4'h0, VECS[i].e_unc});
         read_reg(2'd2, v); check($sformatf("vec%0d recoverable status R2-path", i), v, {12'h0, VECS[i].e_cor});
      end

      // R8 enable read back after table writes
      read_reg(2'd1, v); check("R8 severe enable", v, 16'h0FFF);
      read_reg(2'd3, v); check("R8 recoverable enable", v, 16'h000F);

      // R10 upper bits ignored
      cycle(12'h000, 4'h0, 1'b0, 1'b1, 2'd3, 16'hFFF5);
      read_reg(2'd3, v); check("R10 recoverable enable upper bits", v, 16'h0005);
      cycle(12'h000, 4'h0, 1'b0, 1'b1, 2'd1, 16'hF000);
      read_reg(2'd1, v); check("R10 severe enable upper bits", v, 16'h0000);

      // R7 event on disabled bit: logged, not forwarded
      cycle(12'h010, 4'h0, 1'b0, 1'b0, 2'd0, 16'h0000);
      check("R7 disabled no fwd", {15'h0, fwd_unc}, 16'h0000);
      read_reg(2'd0, v); check("R7 disabled still logged", v, 16'h0010);
      cycle(12'h000, 4'h0, 1'b0, 1'b1, 2'd1, 16'h0FFF);

      // R9 warm reset
      hot_rst_n = 1'b0;
      cycle(12'h004, 4'h0, 1'b0, 1'b0, 2'd0, 16'h0000);
      check("R9 fwd held low", {15'h0, fwd_unc}, 16'h0000);
      read_reg(2'd0, v); check("R9 status kept and logged", v, 16'h0014);
      read_reg(2'd1, v); check("R9 enable kept", v, 16'h0FFF);
      read_reg(2'd3, v); check("R9 recoverable enable kept", v, 16'h0005);
      hot_rst_n = 1'b1;
      cycle(12'h000, 4'h0, 1'b0, 1'b0, 2'd0, 16'h0000);
      check("R9 no late fwd", {14'h0, fwd_unc, fwd_cor}, 16'h0000);

      // R1 power-on reset restores defaults
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      read_reg(2'd0, v); check("R1 status after por", v, 16'h0000);
      read_reg(2'd1, v); check("R1 severe enable after por", v, 16'h0FBF);
      read_reg(2'd3, v); check("R1 recoverable enable after por", v, 16'h0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule